// File: doc/BRIEF.md
# Prescaled Watchdog Down-Counter

This block guards against runaway software. A down-counter starts from all ones and loses one count on every tick of a prescaled clock enable. Software is expected to write to the counter now and then, and each write returns it to all ones. If no write arrives, the counter's most significant bit would eventually clear. On that tick the block raises a sticky interrupt request and reloads itself, so the timeout repeats with a fixed period of 2^(CNT_W-1) ticks.

The tick comes from a free-running divider. A rate flag chooses between a slow enable (one pulse every `SLOW_DIV` clocks) and a fast one (one pulse every `FAST_DIV` clocks). While stop mode is active, the fast rate is used whatever the flag says. Entering stop mode also reloads the counter. A bus hold, a DMA transfer or a memory refresh suspends counting. The current count can be read at any time.

Top module: `prescaled_watchdog`

## Requirements
- R1: After reset the counter reads all ones (0xFFF with the default `CNT_W` of 12), `irq` is 0 and the rate flag is 0, which selects the slow rate.
- R2: With the rate flag at 0, the count drops by exactly one on each slow enable, which fires on every `SLOW_DIV`-th clock after reset. With the flag at 1 it drops by one on each fast enable, which fires on every `FAST_DIV`-th clock. A pulse on `rate_wr` loads `rate_fast` into the flag, and the new rate applies from the next cycle.
- R3: While `stop_mode` is 1, the fast enable drives the counter regardless of the flag.
- R4: A pulse on `kick` loads all ones into the counter at the next edge.
- R5: A pulse on `stop_req` loads all ones into the counter at the next edge.
- R6: On the tick that finds the count at its MSB-only value (0x800), the counter loads all ones instead of clearing its MSB, and `irq` becomes 1. Starting from all ones, this happens on every 2^(CNT_W-1)-th tick, and the MSB the port shows is never 0.
- R7: While any of `bus_hold`, `dma_busy` or `mem_refresh` is 1, a tick leaves the count unchanged. A tick lost this way is not made up later.
- R8: A reload (`kick` or `stop_req`) wins over a decrement in the same cycle. If that same cycle also holds the wrap tick, `irq` is not set.
- R9: `irq` stays at 1 until `irq_clr` is pulsed. If the wrap tick and `irq_clr` fall in the same cycle, `irq` ends up at 1.
- R10: The prescaler runs freely from reset. `kick`, `stop_req` and `rate_wr` do not shift the phase of its enables.
- R11: `count` always shows the present counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| kick | input | 1 | Software write to the counter; reloads all ones |
| rate_wr | input | 1 | Write strobe for the rate flag |
| rate_fast | input | 1 | Rate flag value (1 selects the fast rate, 0 the slow rate) |
| stop_req | input | 1 | Stop-mode entry; reloads all ones |
| stop_mode | input | 1 | Stop mode active; forces the fast rate |
| bus_hold | input | 1 | Bus hold active; freezes counting |
| dma_busy | input | 1 | DMA transfer active; freezes counting |
| mem_refresh | input | 1 | Memory refresh active; freezes counting |
| irq_clr | input | 1 | Clears the sticky interrupt request |
| irq | output | 1 | Sticky timeout interrupt request |
| count | output | CNT_W | Present counter value |

## Verification
There are two same-cycle collisions to cover. The first is a software reload landing on the very tick that would wrap the counter. The second is an interrupt clear landing on that same wrap tick. The bench's reference model knows when the next edge will carry the wrap tick, so it raises `kick` or `irq_clr` for exactly that cycle. It then compares `count` and `irq` on the following cycle: after a kick the count must be all ones with no new interrupt, and after a clear the interrupt must still be set.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   typedef enum logic {
      RATE_SLOW = 1'b0,
      RATE_FAST = 1'b1
   } wdg_rate_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
   parameter int unsigned FAST_DIV = 32,
   parameter int unsigned SLOW_DIV = 512
) (
   input  logic clk,
   input  logic rst_n,
   output logic fast_en,
   output logic slow_en
);
   import wdg_pkg::*;

   localparam int unsigned FAST_W = $clog2(FAST_DIV);
   localparam int unsigned SLOW_W = $clog2(SLOW_DIV);
   localparam bit          SHARED = is_pow2(FAST_DIV) && is_pow2(SLOW_DIV);

   if (FAST_DIV < 2) begin : g_bad_fast
      $error("wdg_prescaler: FAST_DIV must be at least 2");
   end
   if (SLOW_DIV <= FAST_DIV || (SLOW_DIV % FAST_DIV) != 0) begin : g_bad_slow
      $error("wdg_prescaler: SLOW_DIV must be a larger multiple of FAST_DIV");
   end

   if (SHARED) begin : g_shared
      // one binary counter; the fast enable taps its low bits
      logic [SLOW_W-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) div_q <= '0;
         else        div_q <= div_q + 1'b1;
      end
      assign fast_en = &div_q[FAST_W-1:0];
      assign slow_en = &div_q;
   end else begin : g_split
      // two modulo counters started together stay phase aligned
      logic [FAST_W-1:0] fdiv_q;
      logic [SLOW_W-1:0] sdiv_q;
      logic              f_last;
      logic              s_last;
      assign f_last = (fdiv_q == FAST_W'(FAST_DIV - 1));
      assign s_last = (sdiv_q == SLOW_W'(SLOW_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            fdiv_q <= '0;
            sdiv_q <= '0;
         end else begin
            fdiv_q <= f_last ? '0 : fdiv_q + 1'b1;
            sdiv_q <= s_last ? '0 : sdiv_q + 1'b1;
         end
      end
      assign fast_en = f_last;
      assign slow_en = s_last;
   end

   // R10: every slow enable coincides with a fast one (free-running, aligned)
   p_slow_on_fast_r10: assert property (@(posedge clk) disable iff (!rst_n)
      slow_en |-> fast_en);

endmodule

// File: rtl/wdg_tick_sel.sv
module wdg_tick_sel (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_wr,
   input  logic rate_fast,
   input  logic stop_mode,
   input  logic bus_hold,
   input  logic dma_busy,
   input  logic mem_refresh,
   input  logic fast_en,
   input  logic slow_en,
   output logic tick
);
   import wdg_pkg::*;

   wdg_rate_e rate_q;
   logic      frozen;
   logic      raw_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rate_q <= RATE_SLOW;
      else if (rate_wr) rate_q <= wdg_rate_e'(rate_fast);
   end

   assign frozen   = bus_hold | dma_busy | mem_refresh;
   assign raw_tick = (stop_mode || rate_q == RATE_FAST) ? fast_en : slow_en;
   assign tick     = raw_tick & ~frozen;

   // R7: no tick reaches the counter while a bus master owns the bus
   p_no_tick_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_hold || dma_busy || mem_refresh) |-> !tick);
   // R3: in stop mode only fast enables can produce a tick
   p_stop_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && tick) |-> fast_en);

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             kick,
   input  logic             stop_req,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count,
   output logic             irq
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;
   localparam logic [CNT_W-1:0] MSB_ONLY = {1'b1, {(CNT_W-1){1'b0}}};

   if (CNT_W < 2) begin : g_bad_width
      $error("wdg_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             irq_q;
   logic             reload;
   logic             wrap;

   assign reload = kick | stop_req;
   assign wrap   = tick & (cnt_q == MSB_ONLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= ALL_ONES;
         irq_q <= 1'b0;
      end else begin
         if (reload || wrap) cnt_q <= ALL_ONES;
         else if (tick)      cnt_q <= cnt_q - 1'b1;
         if (wrap && !reload) irq_q <= 1'b1;
         else if (irq_clr)    irq_q <= 1'b0;
      end
   end

   assign count = cnt_q;
   assign irq   = irq_q;

   // R4/R5: any reload request leaves all ones after the edge
   p_reload_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (kick || stop_req) |=> (count == ALL_ONES));
   // R6: MSB never seen low
   p_msb_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      count[CNT_W-1]);
   // R2: an ordinary tick lowers the count by exactly one
   p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !kick && !stop_req && count != MSB_ONLY)
      |=> (count == $past(count) - 1'b1));
   // R7: without tick or reload the count holds
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !kick && !stop_req) |=> $stable(count));
   // R9: request sticks until cleared
   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   // R8: a reload suppresses a new request
   p_reload_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && (kick || stop_req)) |=> !irq);

endmodule

// File: rtl/prescaled_watchdog.sv
module prescaled_watchdog #(
   parameter int unsigned CNT_W    = 12,
   parameter int unsigned FAST_DIV = 32,
   parameter int unsigned SLOW_DIV = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic             rate_wr,
   input  logic             rate_fast,
   input  logic             stop_req,
   input  logic             stop_mode,
   input  logic             bus_hold,
   input  logic             dma_busy,
   input  logic             mem_refresh,
   input  logic             irq_clr,
   output logic             irq,
   output logic [CNT_W-1:0] count
);
   logic fast_en;
   logic slow_en;
   logic tick;

   wdg_prescaler #(
      .FAST_DIV (FAST_DIV),
      .SLOW_DIV (SLOW_DIV)
   ) i_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .fast_en (fast_en),
      .slow_en (slow_en)
   );

   wdg_tick_sel i_sel (
      .clk         (clk),
      .rst_n       (rst_n),
      .rate_wr     (rate_wr),
      .rate_fast   (rate_fast),
      .stop_mode   (stop_mode),
      .bus_hold    (bus_hold),
      .dma_busy    (dma_busy),
      .mem_refresh (mem_refresh),
      .fast_en     (fast_en),
      .slow_en     (slow_en),
      .tick        (tick)
   );

   wdg_counter #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .kick     (kick),
      .stop_req (stop_req),
      .irq_clr  (irq_clr),
      .count    (count),
      .irq      (irq)
   );

endmodule

// File: tb/test_prescaled_watchdog.sv
module test_prescaled_watchdog;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 5;
   localparam int FD = 4;
   localparam int SD = 16;
   localparam int MAXV = (1 << W) - 1;
   localparam int HALF = 1 << (W - 1);
   localparam int WD_CYCLES = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic kick = 0, rate_wr = 0, rate_fast = 0, stop_req = 0, stop_mode = 0;
   logic bus_hold = 0, dma_busy = 0, mem_refresh = 0, irq_clr = 0;
   logic irq;
   logic [W-1:0] count;

   int vectors = 0;
   int fails = 0;
   bit done = 0;
   string tag = "R1";

   // reference model state
   int m_div = 0, m_cnt = MAXV, m_irq = 0, m_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prescaled_watchdog #(.CNT_W(W), .FAST_DIV(FD), .SLOW_DIV(SD)) i_prescaled_watchdog (
      .clk(clk), .rst_n(rst_n), .kick(kick), .rate_wr(rate_wr), .rate_fast(rate_fast),
      .stop_req(stop_req), .stop_mode(stop_mode), .bus_hold(bus_hold),
      .dma_busy(dma_busy), .mem_refresh(mem_refresh), .irq_clr(irq_clr),
      .irq(irq), .count(count));

   function automatic bit next_tick();
      bit f = (m_div % FD) == FD - 1;
      bit s = (m_div % SD) == SD - 1;
      bit t = (stop_mode || m_flag) ? f : s;
      return t && !(bus_hold || dma_busy || mem_refresh);
   endfunction

   function automatic bit next_wrap();
      return next_tick() && m_cnt == HALF;
   endfunction

   // one clock: model advances at the edge, comparison at the falling edge
   task automatic step();
      @(posedge clk);
      if (!rst_n) begin
         m_div = 0; m_cnt = MAXV; m_irq = 0; m_flag = 0;
      end else begin
         bit t = next_tick();
         bit w = t && m_cnt == HALF;
         if (kick || stop_req) m_cnt = MAXV;
         else if (w)           m_cnt = MAXV;
         else if (t)           m_cnt = m_cnt - 1;
         if (w && !(kick || stop_req)) m_irq = 1;
         else if (irq_clr)             m_irq = 0;
         if (rate_wr) m_flag = rate_fast;
         m_div = (m_div + 1) % SD;
      end
      @(negedge clk);
      vectors++;
      if (count !== W'(m_cnt) || irq !== m_irq[0]) begin
         fails++;
         $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0d",
                  tag, count, irq, m_cnt, m_irq);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      tag = "R1";
      run(3);
      rst_n = 1'b1;
      run(2);
      // R2/R6/R11 slow rate across two wraps; R9 irq stays set
      tag = "R2_R6_R9_R11_slow";
      run(2 * SD * HALF + 40);
      // R9 clear
      tag = "R9_clear";
      irq_clr = 1; step(); irq_clr = 0; run(5);
      // R2 switch to fast rate
      tag = "R2_fast";
      rate_fast = 1; rate_wr = 1; step(); rate_wr = 0;
      run(FD * HALF + 20);
      // R4 kicks mid-count, R10 prescaler phase untouched
      tag = "R4_R10_kick";
      for (int k = 0; k < 6; k++) begin
         run(7 + k); kick = 1; step(); kick = 0;
      end
      // R7 freeze sources in turn and in a pattern
      tag = "R7_freeze";
      for (int i = 0; i < 300; i++) begin
         bus_hold    = (i % 7) == 3;
         dma_busy    = (i % 11) < 3;
         mem_refresh = (i % 13) == 5;
         step();
      end
      bus_hold = 0; dma_busy = 0; mem_refresh = 0;
      // R3 stop mode forces fast with slow flag; R5 stop entry reload
      tag = "R3_R5_stop";
      rate_fast = 0; rate_wr = 1; step(); rate_wr = 0;
      run(9);
      stop_req = 1; stop_mode = 1; step(); stop_req = 0;
      run(FD * HALF + 30);
      stop_mode = 0;
      run(40);
      // R8 kick on the wrap tick; R9 clear on the wrap tick
      tag = "R8_kick_on_wrap";
      rate_fast = 1; rate_wr = 1; step(); rate_wr = 0;
      irq_clr = 1; step(); irq_clr = 0;
      while (!next_wrap()) step();
      kick = 1; step(); kick = 0; run(3);
      tag = "R8_stop_on_wrap";
      while (!next_wrap()) step();
      stop_req = 1; step(); stop_req = 0; run(3);
      tag = "R9_clear_on_wrap";
      while (!next_wrap()) step();
      irq_clr = 1; step(); irq_clr = 0; run(10);
      // R1 reset mid-run
      tag = "R1_rereset";
      rst_n = 0; run(2); rst_n = 1; run(SD + 3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule